// File: doc/BRIEF.md
# Flash Status Register with Sticky Error Flags

This block holds the 8-bit status word of a flash memory's write state machine and presents it on the low byte of a 16-bit read bus. The operation sequencer drives per-bit set and clear requests. A host clear command input wipes the error flags, and a command-error input raises all four error flags at once. The register reports ready or busy, erase and program suspension, and the erase, program, supply-abort and locked-sector error conditions.

The bits fall into two groups. Ready and the two suspend flags are self-managed: the sequencer may both raise and drop them. The four error flags are sticky: the sequencer can only raise them, and they stay set until the host clear command or reset. Errors therefore pile up across a run of operations, and the host can check them once at the end. Bit 0 is reserved and always reads 0.

The read bus does not show the live register. It shows a copy taken at the start of each read, which is the cycle in which chip enable and output enable are first seen low together. While the strobe stays asserted, that copy is frozen. The host must drop and reassert the strobe to see an update such as a completion. While the supply-abort flag is set, program attempts are refused.

Top module: `flash_sr_top`

## Requirements
- R1: After reset the status register holds 80h (ready, no flags). The read bus is 0000h when no read strobe is active, and a first read returns 0080h.
- R2: A set request on bits 7 to 1 raises that bit at the next clock edge. A set request on bit 0 has no effect, and bit 0 always reads 0.
- R3: Bits 1, 3, 4 and 5 (locked-sector abort, supply abort, program error, erase error) ignore sequencer clear requests. They hold their value until the host clear command or reset.
- R4: A sequencer clear request drops bit 7 (ready), bit 6 (erase suspended) or bit 2 (program suspended) at the next edge. The host clear command does not touch these three bits.
- R5: The host clear command drops bits 1, 3, 4 and 5 at the next edge. When a set and a clear reach the same bit in the same cycle, from either clear source, the bit ends up set.
- R6: A pulse on the command-error input sets bits 1, 3, 4 and 5 together and leaves the other bits as they were.
- R7: One cycle after chip enable and output enable are both sampled low, the bus shows 00h in bits 15:8 and the captured status in bits 7:0. In any cycle after a sample in which either strobe was high, the bus reads 0000h.
- R8: The captured value is taken from the register as it stands in the first cycle of a read. Register changes during a held read do not reach the bus. A fresh read after the strobe is released shows the new value.
- R9: `prog_accept` equals `prog_req` while bit 3 is clear, and it is 0 while bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_set | input | 8 | Per-bit set requests from the sequencer |
| seq_clr | input | 8 | Per-bit clear requests from the sequencer |
| host_clr | input | 1 | Host clear-status command pulse |
| cmd_err | input | 1 | Command-sequence error pulse |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_req | input | 1 | Program attempt from the sequencer |
| prog_accept | output | 1 | Program attempt allowed |
| dout | output | 16 | Read data bus |

## Verification
The assertions take `ce_n` and `oe_n` to be already synchronous to `clk`. They also take the set, clear and error pulses to be single-cycle requests that the sequencer raises only outside reset. The bench drives every input on the falling clock edge and holds it for whole cycles. It returns both strobes high between reads, so that each read opens with a clean assertion edge, apart from the one deliberate held-strobe test.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

  localparam int SR_W = 8;

  typedef enum logic [1:0] {
    SB_RSVD   = 2'd0,
    SB_SELF   = 2'd1,
    SB_STICKY = 2'd2
  } sb_kind_e;

  localparam logic [SR_W-1:0] SR_RESET_VAL = 8'h80;
  localparam logic [SR_W-1:0] SR_SELF_MASK = 8'hC4;
  localparam logic [SR_W-1:0] SR_STKY_MASK = 8'h3A;
  localparam logic [SR_W-1:0] SR_SET_MASK  = SR_SELF_MASK | SR_STKY_MASK;
  localparam int              SR_VPP_BIT   = 3;

  function automatic sb_kind_e sb_kind(input int idx);
    if (SR_STKY_MASK[idx])      return SB_STICKY;
    else if (SR_SELF_MASK[idx]) return SB_SELF;
    else                        return SB_RSVD;
  endfunction

  function automatic logic sb_next(input logic cur, input logic s, input logic c);
    return s | (cur & ~c);
  endfunction

endpackage

// File: rtl/flash_sr_core.sv
module flash_sr_core
  import flash_sr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SR_W-1:0] seq_set,
  input  logic [SR_W-1:0] seq_clr,
  input  logic            host_clr,
  input  logic            cmd_err,
  output logic [SR_W-1:0] sr_q,
  output logic [SR_W-1:0] set_vec,
  output logic [SR_W-1:0] clr_vec
);

  logic [SR_W-1:0] sr_d;

  for (genvar i = 0; i < SR_W; i++) begin : g_bit
    localparam sb_kind_e KIND = sb_kind(i);
    if (KIND == SB_STICKY) begin : g_sticky
      assign set_vec[i] = seq_set[i] | cmd_err;
      assign clr_vec[i] = host_clr;
    end else if (KIND == SB_SELF) begin : g_self
      assign set_vec[i] = seq_set[i];
      assign clr_vec[i] = seq_clr[i];
    end else begin : g_rsvd
      assign set_vec[i] = 1'b0;
      assign clr_vec[i] = 1'b1;
    end
    assign sr_d[i] = sb_next(sr_q[i], set_vec[i], clr_vec[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= SR_RESET_VAL;
    else        sr_q <= sr_d;
  end

  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_clr |=> ((sr_q & SR_STKY_MASK & $past(sr_q)) == ($past(sr_q) & SR_STKY_MASK)));

  assert_self_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_clr & SR_SELF_MASK) == '0) |=> (($past(sr_q) & SR_SELF_MASK & ~sr_q) == '0));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((sr_q & $past(set_vec)) == $past(set_vec)));

  assert_err_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> ((sr_q & SR_STKY_MASK) == SR_STKY_MASK));

  assert_rsvd_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_set[0] |=> !sr_q[0]);

endmodule

// File: rtl/flash_sr_snap.sv
module flash_sr_snap
  import flash_sr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic [SR_W-1:0] sr_q,
  output logic            rd_live,
  output logic            rd_q,
  output logic            capture,
  output logic [SR_W-1:0] snap_q
);

  assign rd_live = ~ce_n & ~oe_n;
  assign capture = rd_live & ~rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      snap_q <= SR_RESET_VAL;
    end else begin
      rd_q <= rd_live;
      if (capture) snap_q <= sr_q;
    end
  end

  assert_snap_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(snap_q));

endmodule

// File: rtl/flash_sr_fmt.sv
module flash_sr_fmt
  import flash_sr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              rd_q,
  input  logic [SR_W-1:0]   snap_q,
  output logic [DATA_W-1:0] dout
);

  localparam int PAD_W = DATA_W - SR_W;

  always_comb begin
    dout = '0;
    if (rd_q) dout = {{PAD_W{1'b0}}, snap_q};
  end

endmodule

// File: rtl/flash_sr_top.sv
module flash_sr_top
  import flash_sr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SR_W-1:0]   seq_set,
  input  logic [SR_W-1:0]   seq_clr,
  input  logic              host_clr,
  input  logic              cmd_err,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              prog_req,
  output logic              prog_accept,
  output logic [DATA_W-1:0] dout
);

  localparam int PAD_W = DATA_W - SR_W;

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] set_vec;
  logic [SR_W-1:0] clr_vec;
  logic            rd_live;
  logic            rd_q;
  logic            capture;
  logic [SR_W-1:0] snap_q;
  logic            vpp_block;

  flash_sr_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .seq_set  (seq_set),
    .seq_clr  (seq_clr),
    .host_clr (host_clr),
    .cmd_err  (cmd_err),
    .sr_q     (sr_q),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec)
  );

  flash_sr_snap u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .sr_q    (sr_q),
    .rd_live (rd_live),
    .rd_q    (rd_q),
    .capture (capture),
    .snap_q  (snap_q)
  );

  flash_sr_fmt #(.DATA_W(DATA_W)) u_fmt (
    .rd_q   (rd_q),
    .snap_q (snap_q),
    .dout   (dout)
  );

  assign vpp_block   = sr_q[SR_VPP_BIT];
  assign prog_accept = prog_req & ~vpp_block;

  assert_read_shows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (dout == {{PAD_W{1'b0}}, $past(sr_q)}));

  assert_idle_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_live |=> (dout == '0));

  assert_prog_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && sr_q[SR_VPP_BIT]) |-> !prog_accept);

endmodule

// File: tb/flash_sr_top_tb.sv
module flash_sr_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  seq_set, seq_clr;
  logic        host_clr, cmd_err, ce_n, oe_n, prog_req;
  logic        prog_accept;
  logic [15:0] dout;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flash_sr_top u_dut (
    .clk(clk), .rst_n(rst_n), .seq_set(seq_set), .seq_clr(seq_clr),
    .host_clr(host_clr), .cmd_err(cmd_err), .ce_n(ce_n), .oe_n(oe_n),
    .prog_req(prog_req), .prog_accept(prog_accept), .dout(dout)
  );

  // {set, clr, host_clr, cmd_err, expected status after the step}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {8'h00, 8'h80, 1'b0, 1'b0, 8'h00},  // R4 drop ready
    {8'h10, 8'h00, 1'b0, 1'b0, 8'h10},  // R2 program error
    {8'h80, 8'h00, 1'b0, 1'b0, 8'h90},  // R2 ready
    {8'h00, 8'h3A, 1'b0, 1'b0, 8'h90},  // R3 sticky ignores clear
    {8'h41, 8'h80, 1'b0, 1'b0, 8'h50},  // R2 bit0 ignored, R4
    {8'h00, 8'h00, 1'b1, 1'b0, 8'h40},  // R5 host clear, R4 bit6 kept
    {8'h00, 8'h00, 1'b0, 1'b1, 8'h7A},  // R6 command error
    {8'h80, 8'h40, 1'b1, 1'b0, 8'h80},  // R4 R5 mixed
    {8'h04, 8'h04, 1'b0, 1'b0, 8'h84},  // R5 set beats clear
    {8'h02, 8'h00, 1'b1, 1'b0, 8'h86},  // R5 set beats host clear
    {8'h00, 8'hFF, 1'b1, 1'b0, 8'h00},  // R3 R4 R5 clear all
    {8'h08, 8'h00, 1'b0, 1'b0, 8'h08}   // R2 supply abort
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] s, input logic [7:0] c, input logic h, input logic e);
    @(negedge clk);
    seq_set = s; seq_clr = c; host_clr = h; cmd_err = e;
    @(negedge clk);
    seq_set = '0; seq_clr = '0; host_clr = 1'b0; cmd_err = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [7:0] exp);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check(req, dout, {8'h00, exp});
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; seq_set = '0; seq_clr = '0; host_clr = 1'b0; cmd_err = 1'b0;
    ce_n = 1'b1; oe_n = 1'b1; prog_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle bus", dout, 16'h0000);
    do_read("R1 reset value", 8'h80);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][25:18], VEC[i][17:10], VEC[i][9], VEC[i][8]);
      do_read($sformatf("R2-vector %0d", i), VEC[i][7:0]);
    end

    // R9: status now 08h, supply abort set
    prog_req = 1'b1;
    @(negedge clk);
    check("R9 refused", {15'd0, prog_accept}, 16'd0);
    step(8'h00, 8'h08, 1'b0, 1'b0);
    check("R9 sequencer clear ignored", {15'd0, prog_accept}, 16'd0);
    step(8'h00, 8'h00, 1'b1, 1'b0);
    check("R9 accepted", {15'd0, prog_accept}, 16'd1);
    prog_req = 1'b0;
    @(negedge clk);
    check("R9 no request", {15'd0, prog_accept}, 16'd0);

    // R7: only one strobe low keeps the bus quiet
    ce_n = 1'b0;
    @(negedge clk);
    check("R7 ce only", dout, 16'h0000);
    ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    check("R7 oe only", dout, 16'h0000);
    oe_n = 1'b1;
    @(negedge clk);

    // R8: held read freezes the view (status is 00h now)
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check("R8 first view", dout, 16'h0000);
    seq_set = 8'h80;
    @(negedge clk);
    seq_set = '0;
    @(negedge clk);
    check("R8 frozen during held read", dout, 16'h0000);
    ce_n = 1'b1;
    @(negedge clk);
    check("R7 released", dout, 16'h0000);
    oe_n = 1'b1;
    @(negedge clk);
    do_read("R8 fresh read", 8'h80);

    // R1: reset again restores 80h and clears sticky bits
    step(8'h00, 8'h00, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_read("R1 reset clears errors", 8'h80);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule